// File: doc/BRIEF.md
# Dual 16/8-bit Counter/Timer Unit

Two identical counter/timers share one register interface. Each timer has a low and a high count byte. A packed mode register gives each timer a four-bit configuration field: gate enable, event/tick source select and a two-bit operating mode. A control register holds a run bit, an interrupt enable and a sticky overflow flag for each timer.

Each timer works in one of two modes. In the wide mode the two bytes form a single 16-bit up-counter that wraps to zero and raises its flag. In the reload mode only the low byte counts, and on wrap it takes the high byte's value. The count source is either a prescaled system tick or falling edges on a per-timer event pin, which is synchronised inside the block. A per-timer gate pin can further qualify counting. Software reads and writes every register through a byte-wide port, and each timer drives an interrupt request from its flag.

Top module: `timer_pair_unit`

## Requirements
- R1: After reset, all registers (mode, control, all count bytes) read 0, and `flag_o` and `irq_o` are 0.
- R2: Address map for writes and reads: 0 = mode, 1 = control, 2/3 = timer 0 low/high, 4/5 = timer 1 low/high. In the mode byte, bits [3:0] belong to timer 0 and [7:4] to timer 1, each ordered {gate, ext, m1, m0} from MSB to LSB. In the control byte, timer t uses bit 4t for run, 4t+1 for interrupt enable and 4t+2 for flag. Every register reads back what was written.
- R3: With m1m0 = 01, {high,low} is one 16-bit count that advances by one per qualified step. A step from 0xFFFF gives 0x0000 and sets the flag; there is no reload.
- R4: With m1m0 = 10, only the low byte advances. A step from 0xFF loads the low byte from the high byte and sets the flag, and the high byte never changes except by a write. The first interval starts from whatever the low byte held.
- R5: With ext = 1, the timer steps once per high-to-low transition of its event pin and ignores `tick_i`. With ext = 0, it steps on each cycle with `tick_i` high.
- R6: A timer steps only while its run bit is 1. With gate = 1, its gate pin must also be high (seen two cycles after the pin changes).
- R7: The flag stays set until software writes 0 to it. An overflow in the same cycle as a clearing control write leaves the flag set.
- R8: `irq_o[t]` is high exactly when timer t's flag and interrupt enable are both 1.
- R9: A write to either count byte of a timer in a cycle where that timer would step stores the written value, and the step is dropped.
- R10: With m1m0 = 00 or 11, the count never changes except by a write.
- R11: The two timers are independent and behave identically in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Prescaled system tick |
| evt_i | input | 2 | Per-timer external event pins (asynchronous) |
| gate_i | input | 2 | Per-timer external gate pins (asynchronous) |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 3 | Read address |
| rd_data_o | output | 8 | Read data (combinational) |
| flag_o | output | 2 | Overflow flags |
| irq_o | output | 2 | Interrupt requests |

## Verification
A wrong count state shows up in two ways: at the next read of a count byte, and one cycle after the faulty step as a missing or spurious change on `flag_o`/`irq_o`. A broken reload path or a corrupted high byte appears only after the first wrap, so counts are run through several wraps from random start and reload values. Synchroniser or edge-detect faults show up as an event count that is off by one or more after a pulse train, and gate faults as counts that move while the gate pin is low.

// File: rtl/timer_pkg.sv
package timer_pkg;
  typedef enum logic [1:0] {
    TM_IDLE0  = 2'b00,
    TM_WIDE   = 2'b01,
    TM_RELOAD = 2'b10,
    TM_IDLE3  = 2'b11
  } tm_mode_e;

  typedef struct packed {
    logic     gate;
    logic     ext;
    tm_mode_e mode;
  } tmr_cfg_t;

  localparam int CFG_W  = 4;
  localparam int CTL_RUN  = 0;
  localparam int CTL_IE   = 1;
  localparam int CTL_FLAG = 2;
endpackage

// File: rtl/sync_ff.sv
module sync_ff #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else begin
      pipe_q[0] <= d_i;
      for (int k = 1; k < STAGES; k++) pipe_q[k] <= pipe_q[k-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/timer_core.sv
module timer_core
  import timer_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  tmr_cfg_t            cfg_i,
  input  logic                run_i,
  input  logic                gate_lvl_i,
  input  logic                evt_fall_i,
  input  logic                tick_i,
  input  logic                wr_lo_i,
  input  logic                wr_hi_i,
  input  logic [BYTE_W-1:0]   wr_data_i,
  output logic [2*BYTE_W-1:0] cnt_o,
  output logic                ovf_o
);
  logic [BYTE_W-1:0] lo_q, hi_q, lo_d, hi_d;
  logic step, inc, wr_any;

  assign wr_any = wr_lo_i | wr_hi_i;
  assign step   = run_i & (~cfg_i.gate | gate_lvl_i) & (cfg_i.ext ? evt_fall_i : tick_i);
  assign inc    = step & ~wr_any;

  always_comb begin
    lo_d  = lo_q;
    hi_d  = hi_q;
    ovf_o = 1'b0;
    if (wr_any) begin
      if (wr_lo_i) lo_d = wr_data_i;
      if (wr_hi_i) hi_d = wr_data_i;
    end else if (inc) begin
      unique case (cfg_i.mode)
        TM_WIDE:   {ovf_o, hi_d, lo_d} = {1'b0, hi_q, lo_q} + 1'b1;
        TM_RELOAD: begin
          if (&lo_q) begin
            lo_d  = hi_q;
            ovf_o = 1'b1;
          end else begin
            lo_d = lo_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  assign cnt_o = {hi_q, lo_q};

  a_r6_halt_when_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !wr_any) |=> ($stable(lo_q) && $stable(hi_q)));
  a_r4_high_byte_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.mode == TM_RELOAD && !wr_hi_i) |=> $stable(hi_q));
  a_r4_reload_from_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && cfg_i.mode == TM_RELOAD) |=> (lo_q == $past(hi_q)));
  a_r10_idle_modes_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cfg_i.mode == TM_IDLE0 || cfg_i.mode == TM_IDLE3) && !wr_any)
      |=> ($stable(lo_q) && $stable(hi_q)));
  a_r9_write_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo_i |=> (lo_q == $past(wr_data_i)));
endmodule

// File: rtl/timer_pair_unit.sv
module timer_pair_unit
  import timer_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int N_TMR       = 2,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = $clog2(2 + 2 * N_TMR)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [N_TMR-1:0]  evt_i,
  input  logic [N_TMR-1:0]  gate_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic [N_TMR-1:0]  flag_o,
  output logic [N_TMR-1:0]  irq_o
);
  localparam int MODE_W = CFG_W * N_TMR;
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(1);

  logic [MODE_W-1:0] mode_q;
  logic [N_TMR-1:0]  run_q, ie_q, flag_q, ovf;
  logic [N_TMR-1:0]  evt_s, evt_prev_q, evt_fall, gate_s;
  logic [2*BYTE_W-1:0] cnt [N_TMR];
  logic [BYTE_W-1:0] ctrl_rd;
  logic wr_mode, wr_ctrl;

  sync_ff #(.W(N_TMR), .STAGES(SYNC_STAGES)) u_evt_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(evt_i), .q_o(evt_s));
  sync_ff #(.W(N_TMR), .STAGES(SYNC_STAGES)) u_gate_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(gate_i), .q_o(gate_s));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) evt_prev_q <= '0;
    else         evt_prev_q <= evt_s;
  end
  assign evt_fall = evt_prev_q & ~evt_s;

  assign wr_mode = wr_en_i && wr_addr_i == A_MODE;
  assign wr_ctrl = wr_en_i && wr_addr_i == A_CTRL;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mode_q <= '0;
    else if (wr_mode) mode_q <= wr_data_i[MODE_W-1:0];
  end

  for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
    localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(2 + 2 * i);
    localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(3 + 2 * i);
    tmr_cfg_t cfg;
    assign cfg = tmr_cfg_t'(mode_q[CFG_W*i +: CFG_W]);

    timer_core #(.BYTE_W(BYTE_W)) u_core (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cfg_i      (cfg),
      .run_i      (run_q[i]),
      .gate_lvl_i (gate_s[i]),
      .evt_fall_i (evt_fall[i]),
      .tick_i     (tick_i),
      .wr_lo_i    (wr_en_i && wr_addr_i == A_LO),
      .wr_hi_i    (wr_en_i && wr_addr_i == A_HI),
      .wr_data_i  (wr_data_i),
      .cnt_o      (cnt[i]),
      .ovf_o      (ovf[i])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        run_q[i]  <= 1'b0;
        ie_q[i]   <= 1'b0;
        flag_q[i] <= 1'b0;
      end else if (wr_ctrl) begin
        run_q[i]  <= wr_data_i[CFG_W*i + CTL_RUN];
        ie_q[i]   <= wr_data_i[CFG_W*i + CTL_IE];
        flag_q[i] <= wr_data_i[CFG_W*i + CTL_FLAG] | ovf[i];  // hardware set wins
      end else begin
        flag_q[i] <= flag_q[i] | ovf[i];
      end
    end

    a_r7_flag_on_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ovf[i] |=> flag_q[i]);
    a_r7_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q[i] && !wr_ctrl) |=> flag_q[i]);
  end

  always_comb begin
    ctrl_rd = '0;
    for (int i = 0; i < N_TMR; i++) begin
      ctrl_rd[CFG_W*i + CTL_RUN]  = run_q[i];
      ctrl_rd[CFG_W*i + CTL_IE]   = ie_q[i];
      ctrl_rd[CFG_W*i + CTL_FLAG] = flag_q[i];
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == A_MODE)      rd_data_o = BYTE_W'(mode_q);
    else if (rd_addr_i == A_CTRL) rd_data_o = ctrl_rd;
    else begin
      for (int i = 0; i < N_TMR; i++) begin
        if (rd_addr_i == ADDR_W'(2 + 2 * i)) rd_data_o = cnt[i][BYTE_W-1:0];
        if (rd_addr_i == ADDR_W'(3 + 2 * i)) rd_data_o = cnt[i][2*BYTE_W-1:BYTE_W];
      end
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & ie_q;
endmodule

// File: tb/tb_timer_pair_unit.sv
module tb_timer_pair_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [1:0] evt = 2'b11;
  logic [1:0] gate = 2'b00;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [1:0] flag, irq;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  timer_pair_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .evt_i(evt), .gate_i(gate),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .flag_o(flag), .irq_o(irq));

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      @(negedge clk);
      tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
    end
  endtask

  function automatic logic [16:0] exp_wide(input logic [15:0] s, input int n);
    int t = int'(s) + n;
    return {t >= 65536, t[15:0]};
  endfunction

  function automatic logic [8:0] exp_reload(input logic [7:0] lo, input logic [7:0] hi, input int n);
    logic f = 1'b0;
    for (int k = 0; k < n; k++) begin
      if (lo == 8'hFF) begin lo = hi; f = 1'b1; end
      else lo = lo + 8'd1;
    end
    return {f, lo};
  endfunction

  task automatic setup(input int t, input logic [3:0] cfg, input logic [7:0] lo, input logic [7:0] hi);
    wr(3'd1, 8'h00);
    wr(3'd0, 8'(cfg) << (4 * t));
    wr(3'(2 + 2 * t), lo);
    wr(3'(3 + 2 * t), hi);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d, lo, hi;
    logic [16:0] ew;
    logic [8:0] er;
    void'($urandom(32'd20240611));
    #23 rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      check("R1 reset reg", d, 0);
    end
    check("R1 flag", flag, 0);
    check("R1 irq", irq, 0);

    // R2 readback
    wr(3'd0, 8'hA5); rd(3'd0, d); check("R2 mode readback", d, 8'hA5);
    wr(3'd1, 8'h22); rd(3'd1, d); check("R2 ctrl readback", d, 8'h22);
    wr(3'd1, 8'h00);
    wr(3'd5, 8'h3C); rd(3'd5, d); check("R2 t1 high readback", d, 8'h3C);

    // R3 mode 1 wrap, no reload
    setup(0, 4'b0001, 8'hFD, 8'hFF);
    wr(3'd1, 8'h01);
    ticks(5);
    rd(3'd2, lo); rd(3'd3, hi);
    check("R3 wrap count", {hi, lo}, 16'h0002);
    check("R3 flag set", flag[0], 1);
    check("R8 irq off without enable", irq[0], 0);
    wr(3'd1, 8'h07);
    check("R8 irq with enable", irq[0], 1);

    // R7 sticky, then clear
    ticks(3);
    check("R7 flag sticky", flag[0], 1);
    wr(3'd1, 8'h01);
    check("R7 flag cleared", flag[0], 0);
    check("R8 irq follows flag", irq[0], 0);

    // R4 mode 2 reload, high byte kept
    setup(0, 4'b0010, 8'hFE, 8'hF0);
    wr(3'd1, 8'h01);
    ticks(3);
    rd(3'd2, lo); rd(3'd3, hi);
    check("R4 reload low", lo, 8'hF1);
    check("R4 high kept", hi, 8'hF0);
    check("R4 flag", flag[0], 1);

    // R7 overflow coincident with clearing write
    setup(0, 4'b0010, 8'hFF, 8'h10);
    wr(3'd1, 8'h01);
    @(negedge clk);
    tick = 1'b1; wr_en = 1'b1; wr_addr = 3'd1; wr_data = 8'h01;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    check("R7 set wins over clear", flag[0], 1);
    rd(3'd2, d); check("R4 reload on coincident", d, 8'h10);

    // R9 write wins over step
    setup(0, 4'b0010, 8'h20, 8'h00);
    wr(3'd1, 8'h01);
    @(negedge clk);
    tick = 1'b1; wr_en = 1'b1; wr_addr = 3'd2; wr_data = 8'h40;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    rd(3'd2, d); check("R9 low write wins", d, 8'h40);
    setup(0, 4'b0001, 8'h20, 8'h00);
    wr(3'd1, 8'h01);
    @(negedge clk);
    tick = 1'b1; wr_en = 1'b1; wr_addr = 3'd3; wr_data = 8'h55;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    rd(3'd2, lo); rd(3'd3, hi);
    check("R9 high write drops step", {hi, lo}, 16'h5520);

    // R5 event counting, tick ignored
    setup(0, 4'b0101, 8'h00, 8'h00);
    wr(3'd1, 8'h01);
    ticks(10);
    rd(3'd2, d); check("R5 tick ignored in event mode", d, 0);
    for (int k = 0; k < 7; k++) begin
      @(negedge clk); evt[0] = 1'b0;
      repeat (4) @(negedge clk);
      evt[0] = 1'b1;
      repeat (4) @(negedge clk);
    end
    rd(3'd2, d); check("R5 falling edges counted", d, 7);

    // R6 run and gate
    setup(0, 4'b0001, 8'h10, 8'h00);
    ticks(10);
    rd(3'd2, d); check("R6 stopped holds", d, 8'h10);
    setup(0, 4'b1001, 8'h10, 8'h00);
    gate[0] = 1'b0;
    wr(3'd1, 8'h01);
    ticks(10);
    rd(3'd2, d); check("R6 gate low holds", d, 8'h10);
    gate[0] = 1'b1;
    repeat (4) @(negedge clk);
    ticks(10);
    rd(3'd2, d); check("R6 gate high counts", d, 8'h1A);
    gate[0] = 1'b0;

    // R10 idle modes
    setup(1, 4'b0000, 8'h33, 8'h44);
    wr(3'd1, 8'h10);
    ticks(8);
    rd(3'd4, d); check("R10 mode 00 holds", d, 8'h33);
    setup(1, 4'b0011, 8'h33, 8'h44);
    wr(3'd1, 8'h10);
    ticks(8);
    rd(3'd4, d); check("R10 mode 11 holds", d, 8'h33);

    // R11 independence: timer 1 runs, timer 0 stopped
    setup(0, 4'b0001, 8'h77, 8'h00);
    wr(3'd0, 8'h21);
    wr(3'd4, 8'hFE); wr(3'd5, 8'h80);
    wr(3'd1, 8'h10);
    ticks(4);
    rd(3'd2, d); check("R11 timer0 unaffected", d, 8'h77);
    rd(3'd4, d); check("R11 timer1 reload", d, 8'h82);
    check("R11 flags", flag, 2'b10);

    // Random: R3, R4, R11
    for (int it = 0; it < 24; it++) begin
      int t = int'($urandom_range(1, 0));
      int md = int'($urandom_range(2, 1));
      int n = int'($urandom_range(600, 0));
      logic [7:0] l0 = 8'($urandom);
      logic [7:0] h0 = 8'($urandom);
      if (md == 1 && $urandom_range(1, 0) == 1) h0 = 8'hFF;
      setup(t, 4'(md), l0, h0);
      wr(3'd1, 8'(1 << (4 * t)));
      ticks(n);
      rd(3'(2 + 2 * t), lo); rd(3'(3 + 2 * t), hi);
      if (md == 1) begin
        ew = exp_wide({h0, l0}, n);
        check("R3 random wide count", {hi, lo}, ew[15:0]);
        check("R3 random wide flag", flag[t], ew[16]);
      end else begin
        er = exp_reload(l0, h0, n);
        check("R4 random reload count", lo, er[7:0]);
        check("R4 random high kept", hi, h0);
        check("R4 random reload flag", flag[t], er[8]);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule